// File: doc/BRIEF.md
# Raster Timing Generator with Packed Configuration Words

This block produces the horizontal and vertical timing of a raster display from a single pixel clock. It generates pixel and line counters, active-low sync pulses, a blanking flag, an active-video flag and the current pixel coordinates. Downstream logic, such as a pixel fetcher or a cursor overlay, uses these outputs.

The timing comes from two packed 32-bit words written over a simple write-only register port: one word for the horizontal line and one for the vertical frame. Horizontal quantities are programmed in units of four pixels, and vertical quantities in lines. A written timing word goes into a shadow register. The counters switch to it at the next frame boundary, so a frame never mixes two timings. A third word, the control word, holds video enable, forced blank and cursor enable. It takes effect on the cycle after it is written.

Each line runs active region, front porch, sync, back porch. The frame runs through the same four phases in lines.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal word (address 0) holds active/4 in bits 8:0, front porch/4 in bits 13:9, sync/4 in bits 20:14 and back porch/4 in bits 26:21. A line lasts active + front porch + sync + back porch pixel clocks, in that order.
- R2: The horizontal active field decodes to 8192 pixels for code 0, 8196 pixels for code 1, and 4×N pixels for any other code N.
- R3: When bit 0 and bit 31 of the horizontal word are both set, the active width is four pixels less than the decoded value. Either bit alone has no effect.
- R4: The vertical word (address 1) holds active rows in bits 10:0, front porch in bits 15:11, sync in bits 21:16 and back porch in bits 27:22, all in lines. A frame lasts the sum of the four times the line length.
- R5: `hSyncN` is low exactly during the horizontal sync span of every line. `vSyncN` is low on every pixel of the vertical sync lines.
- R6: A timing word written during a frame does not change that frame. It takes effect from the first pixel of the next frame.
- R7: The control word (address 2) holds bit 0 video enable, bit 1 forced blank and bit 2 cursor enable, each taking effect the cycle after the write. `blankOut` is high unless the position is active, video is enabled and forced blank is clear. `cursorEn` mirrors bit 2. The counters keep running while blanked.
- R8: `activeVideo` is high whenever the position lies inside the active rows and columns, whatever the control word holds.
- R9: `posX` and `posY` give the pixel column and row during active video, and are both zero outside it.
- R10: Reset sets both counters to zero, clears the control bits and loads the reset timing parameters into both the working and shadow timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 control |
| cfgWdata | input | 32 | Register write data |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| blankOut | output | 1 | High when the pixel must be blanked |
| activeVideo | output | 1 | High inside the active region |
| cursorEn | output | 1 | Cursor enable from the control word |
| posX | output | 14 | Pixel column during active video, else 0 |
| posY | output | 12 | Pixel row during active video, else 0 |

## Verification
The counter-bound assertions take for granted that the programmed vertical total is at least one line and that the horizontal total is at least a few pixels. The stimulus therefore always programs at least one active row and an active code of two or more, or one of the wide special codes. The assertions also assume that timing words change only through the port, so that the working timing holds still between frame boundaries. The bench writes its timing words in the first cycles after a frame marker, so each write lands well inside a frame rather than on its last edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Counter widths: enough for the widest decoded line and tallest frame
  localparam int HCW = 14;
  localparam int VCW = 12;

  // Horizontal field widths (units of four pixels) and derived positions
  localparam int H_ACT_W   = 9;
  localparam int H_FP_W    = 5;
  localparam int H_SYNC_W  = 7;
  localparam int H_BP_W    = 6;
  localparam int H_FP_LSB   = H_ACT_W;
  localparam int H_SYNC_LSB = H_FP_LSB + H_FP_W;
  localparam int H_BP_LSB   = H_SYNC_LSB + H_SYNC_W;
  localparam int H_ODD_BIT  = 31;
  localparam int UNIT_SHIFT = 2;

  // Vertical field widths (lines) and derived positions
  localparam int V_ACT_W   = 11;
  localparam int V_FP_W    = 5;
  localparam int V_SYNC_W  = 6;
  localparam int V_BP_W    = 6;
  localparam int V_FP_LSB   = V_ACT_W;
  localparam int V_SYNC_LSB = V_FP_LSB + V_FP_W;
  localparam int V_BP_LSB   = V_SYNC_LSB + V_SYNC_W;

  // Special active-width codes
  localparam int ACT_CODE0_PIX = 8192;
  localparam int ACT_CODE1_PIX = 8196;
  localparam int ODD_TRIM_PIX  = 4;

  // Register addresses
  localparam int ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_HORIZ = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VERT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;

  // Control word bits
  localparam int CTL_VIDEO_BIT  = 0;
  localparam int CTL_BLANK_BIT  = 1;
  localparam int CTL_CURSOR_BIT = 2;

  typedef struct packed {
    logic                odd;
    logic [H_BP_W-1:0]   bp;
    logic [H_SYNC_W-1:0] sync;
    logic [H_FP_W-1:0]   fp;
    logic [H_ACT_W-1:0]  act;
  } rtg_hfields_t;

  typedef struct packed {
    logic [V_BP_W-1:0]   bp;
    logic [V_SYNC_W-1:0] sync;
    logic [V_FP_W-1:0]   fp;
    logic [V_ACT_W-1:0]  act;
  } rtg_vfields_t;

  // Decoded span boundaries used by the counters
  typedef struct packed {
    logic [HCW-1:0] hActEnd;
    logic [HCW-1:0] hSyncBeg;
    logic [HCW-1:0] hSyncEnd;
    logic [HCW-1:0] hTotal;
    logic [VCW-1:0] vActEnd;
    logic [VCW-1:0] vSyncBeg;
    logic [VCW-1:0] vSyncEnd;
    logic [VCW-1:0] vTotal;
  } rtg_timing_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic videoOn;
    logic forceBlank;
  } rtg_strobe_t;

  function automatic logic [HCW-1:0] activeWidth(rtg_hfields_t h);
    logic [HCW-1:0] w;
    if (h.act == '0)
      w = HCW'(ACT_CODE0_PIX);
    else if (h.act == H_ACT_W'(1))
      w = HCW'(ACT_CODE1_PIX);
    else
      w = HCW'(h.act) << UNIT_SHIFT;
    if (h.act[0] && h.odd)
      w = w - HCW'(ODD_TRIM_PIX);
    return w;
  endfunction

  function automatic rtg_timing_t buildTiming(rtg_hfields_t h, rtg_vfields_t v);
    rtg_timing_t t;
    t.hActEnd  = activeWidth(h);
    t.hSyncBeg = t.hActEnd  + (HCW'(h.fp)   << UNIT_SHIFT);
    t.hSyncEnd = t.hSyncBeg + (HCW'(h.sync) << UNIT_SHIFT);
    t.hTotal   = t.hSyncEnd + (HCW'(h.bp)   << UNIT_SHIFT);
    t.vActEnd  = VCW'(v.act);
    t.vSyncBeg = t.vActEnd  + VCW'(v.fp);
    t.vSyncEnd = t.vSyncBeg + VCW'(v.sync);
    t.vTotal   = t.vSyncEnd + VCW'(v.bp);
    return t;
  endfunction

endpackage

// File: rtl/rtg_control.sv
module rtg_control
  import rtg_pkg::*;
#(
  parameter logic [31:0] H_RESET_WORD = 32'h0020_4204,
  parameter logic [31:0] V_RESET_WORD = 32'h0041_0804
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              frameEnd,
  output rtg_timing_t       timing,
  output rtg_strobe_t       strobe,
  output logic              cursorEn
);

  localparam rtg_hfields_t H_RST = '{
    odd:  H_RESET_WORD[H_ODD_BIT],
    bp:   H_RESET_WORD[H_BP_LSB   +: H_BP_W],
    sync: H_RESET_WORD[H_SYNC_LSB +: H_SYNC_W],
    fp:   H_RESET_WORD[H_FP_LSB   +: H_FP_W],
    act:  H_RESET_WORD[0          +: H_ACT_W]
  };
  localparam rtg_vfields_t V_RST = '{
    bp:   V_RESET_WORD[V_BP_LSB   +: V_BP_W],
    sync: V_RESET_WORD[V_SYNC_LSB +: V_SYNC_W],
    fp:   V_RESET_WORD[V_FP_LSB   +: V_FP_W],
    act:  V_RESET_WORD[0          +: V_ACT_W]
  };

  rtg_hfields_t shadowH, wrH;
  rtg_vfields_t shadowV, wrV;
  rtg_timing_t  timingQ;
  logic         videoQ, blankQ, cursorQ;

  // Bits 30:28 are reserved in both timing words
  logic unusedRsvd;
  assign unusedRsvd = ^cfgWdata[30:28];

  always_comb begin
    wrH.odd  = cfgWdata[H_ODD_BIT];
    wrH.bp   = cfgWdata[H_BP_LSB   +: H_BP_W];
    wrH.sync = cfgWdata[H_SYNC_LSB +: H_SYNC_W];
    wrH.fp   = cfgWdata[H_FP_LSB   +: H_FP_W];
    wrH.act  = cfgWdata[0          +: H_ACT_W];
    wrV.bp   = cfgWdata[V_BP_LSB   +: V_BP_W];
    wrV.sync = cfgWdata[V_SYNC_LSB +: V_SYNC_W];
    wrV.fp   = cfgWdata[V_FP_LSB   +: V_FP_W];
    wrV.act  = cfgWdata[0          +: V_ACT_W];
  end

  // Shadow registers and control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowH <= H_RST;
      shadowV <= V_RST;
      videoQ  <= 1'b0;
      blankQ  <= 1'b0;
      cursorQ <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_HORIZ: shadowH <= wrH;
        ADDR_VERT:  shadowV <= wrV;
        ADDR_CTRL: begin
          videoQ  <= cfgWdata[CTL_VIDEO_BIT];
          blankQ  <= cfgWdata[CTL_BLANK_BIT];
          cursorQ <= cfgWdata[CTL_CURSOR_BIT];
        end
        default: ;
      endcase
    end
  end

  // Working timing: swapped in only on the last pixel of a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      timingQ <= buildTiming(H_RST, V_RST);
    else if (frameEnd)
      timingQ <= buildTiming(shadowH, shadowV);
  end

  assign timing            = timingQ;
  assign strobe.videoOn    = videoQ;
  assign strobe.forceBlank = blankQ;
  assign cursorEn          = cursorQ;

  // R6: timing is frozen everywhere except on a frame boundary
  p_hold_midframe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(timing));

  // R7: control bits follow the written word one cycle later
  p_ctrl_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == ADDR_CTRL) |=>
      (strobe.videoOn    == $past(cfgWdata[CTL_VIDEO_BIT]) &&
       strobe.forceBlank == $past(cfgWdata[CTL_BLANK_BIT]) &&
       cursorEn          == $past(cfgWdata[CTL_CURSOR_BIT])));

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  rtg_timing_t    timing,
  input  rtg_strobe_t    strobe,
  output logic           frameEnd,
  output logic           hSyncN,
  output logic           vSyncN,
  output logic           blankOut,
  output logic           activeVideo,
  output logic [HCW-1:0] posX,
  output logic [VCW-1:0] posY
);

  logic [HCW-1:0] xCnt;
  logic [VCW-1:0] yCnt;
  logic           lastX, lastY, inX, inY;

  assign lastX    = (xCnt == timing.hTotal - HCW'(1));
  assign lastY    = ({1'b0, yCnt} + (VCW+1)'(1)) >= {1'b0, timing.vTotal};
  assign frameEnd = lastX && lastY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt <= '0;
      yCnt <= '0;
    end else if (lastX) begin
      xCnt <= '0;
      yCnt <= lastY ? '0 : yCnt + VCW'(1);
    end else begin
      xCnt <= xCnt + HCW'(1);
    end
  end

  assign inX         = xCnt < timing.hActEnd;
  assign inY         = yCnt < timing.vActEnd;
  assign activeVideo = inX && inY;
  assign hSyncN      = !((xCnt >= timing.hSyncBeg) && (xCnt < timing.hSyncEnd));
  assign vSyncN      = !((yCnt >= timing.vSyncBeg) && (yCnt < timing.vSyncEnd));
  assign blankOut    = !(activeVideo && strobe.videoOn && !strobe.forceBlank);
  assign posX        = activeVideo ? xCnt : '0;
  assign posY        = activeVideo ? yCnt : '0;

  // R1: pixel counter stays inside the programmed line
  p_x_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    xCnt < timing.hTotal);

  // R1: the last pixel of a line is followed by column zero
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    lastX |=> (xCnt == '0));

  // R4: line counter stays inside the programmed frame
  p_y_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    yCnt < timing.vTotal);

  // R5: horizontal sync never overlaps active video
  p_sync_outside_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    !hSyncN |-> !activeVideo);

  // R7: disabled or forced-blank video is always blanked
  p_blank_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.videoOn || strobe.forceBlank) |-> blankOut);

  // R9: coordinates read zero outside the active region
  p_pos_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !activeVideo |-> (posX == '0 && posY == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter logic [31:0] H_RESET_WORD = 32'h0020_4204,
  parameter logic [31:0] V_RESET_WORD = 32'h0041_0804
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic        hSyncN,
  output logic        vSyncN,
  output logic        blankOut,
  output logic        activeVideo,
  output logic        cursorEn,
  output logic [13:0] posX,
  output logic [11:0] posY
);

  rtg_timing_t timing;
  rtg_strobe_t strobe;
  logic        frameEnd;

  rtg_control #(
    .H_RESET_WORD(H_RESET_WORD),
    .V_RESET_WORD(V_RESET_WORD)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .frameEnd (frameEnd),
    .timing   (timing),
    .strobe   (strobe),
    .cursorEn (cursorEn)
  );

  rtg_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .timing      (timing),
    .strobe      (strobe),
    .frameEnd    (frameEnd),
    .hSyncN      (hSyncN),
    .vSyncN      (vSyncN),
    .blankOut    (blankOut),
    .activeVideo (activeVideo),
    .posX        (posX),
    .posY        (posY)
  );

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] H_RST = 32'h0020_4204; // 16 active, line 28
  localparam logic [31:0] V_RST = 32'h0041_0804; // 4 rows, frame 7 lines

  typedef struct packed {
    logic [31:0] h;
    logic [31:0] v;
    int          w;
    int          line;
    int          frame;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS[NVEC] = '{
    '{32'h0020_8204, 32'h0042_0803,   16,   32,  224}, // plain code 4
    '{32'h8020_4405, 32'h0001_0002,   16,   32,   96}, // odd pair trims
    '{32'h0020_4405, 32'h0042_0803,   20,   36,  252}, // bit 0 alone
    '{32'h0020_4200, 32'h0000_0001, 8192, 8204, 8204}, // code 0
    '{32'h0000_4001, 32'h0000_0001, 8196, 8200, 8200}, // code 1
    '{32'h8000_4001, 32'h0000_0001, 8192, 8196, 8196}, // code 1 trimmed
    '{32'h0000_8002, 32'h0001_0002,    8,   16,   48}, // zero porches
    '{32'h8020_4206, 32'h0001_0002,   24,   36,  108}  // bit 31 alone
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        hSyncN, vSyncN, blankOut, activeVideo, cursorEn;
  logic [13:0] posX;
  logic [11:0] posY;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int mHA, mHSB, mHSE, mHT, mVA, mVSB, mVSE, mVT;
  int bx, by;
  bit mVid, mForce, mCur;
  logic [31:0] pendH, pendV;

  // Measurements taken from the outputs
  int frameCnt, act0, line0Len, fLen, fAct0, fLine, frameSeen;
  bit lineDone;
  bit lastActive, lastBlank;
  int lastPosX;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen #(.H_RESET_WORD(H_RST), .V_RESET_WORD(V_RST)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .blankOut(blankOut),
    .activeVideo(activeVideo), .cursorEn(cursorEn), .posX(posX), .posY(posY)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Timing from the requirement text (R1..R4 field positions)
  task automatic setTiming(logic [31:0] h, logic [31:0] v);
    int w;
    case (h[8:0])
      9'd0:    w = 8192;
      9'd1:    w = 8196;
      default: w = 4 * int'(h[8:0]);
    endcase
    if (h[0] && h[31]) w = w - 4;
    mHA  = w;
    mHSB = mHA  + 4 * int'(h[13:9]);
    mHSE = mHSB + 4 * int'(h[20:14]);
    mHT  = mHSE + 4 * int'(h[26:21]);
    mVA  = int'(v[10:0]);
    mVSB = mVA  + int'(v[15:11]);
    mVSE = mVSB + int'(v[21:16]);
    mVT  = mVSE + int'(v[27:22]);
  endtask

  // One pixel clock: compare at mid-cycle, then advance the model
  task automatic step(bit we, logic [1:0] addr, logic [31:0] data);
    bit expAct, lineStart, frameStart;
    cfgWe = we; cfgAddr = addr; cfgWdata = data;
    #1;
    expAct = (bx < mHA) && (by < mVA);
    chk("R5 hSyncN", int'(hSyncN), int'(!(bx >= mHSB && bx < mHSE)));
    chk("R5 vSyncN", int'(vSyncN), int'(!(by >= mVSB && by < mVSE)));
    chk("R8 activeVideo", int'(activeVideo), int'(expAct));
    chk("R7 blankOut", int'(blankOut), int'(!(expAct && mVid && !mForce)));
    chk("R7 cursorEn", int'(cursorEn), int'(mCur));
    chk("R9 posX", int'(posX), expAct ? bx : 0);
    chk("R9 posY", int'(posY), expAct ? by : 0);

    lineStart  = activeVideo && (posX == '0);
    frameStart = lineStart && (posY == '0);
    if (frameStart) begin
      if (frameCnt != 0) begin
        fLen = frameCnt; fAct0 = act0; fLine = line0Len; frameSeen++;
      end
      frameCnt = 0; act0 = 0; line0Len = 0; lineDone = 0;
    end else if (lineStart) begin
      lineDone = 1;
    end
    frameCnt++;
    if (!lineDone) begin
      line0Len++;
      if (activeVideo) act0++;
    end
    lastActive = activeVideo;
    lastBlank  = blankOut;
    lastPosX   = int'(posX);

    @(posedge clk);
    if (bx == mHT - 1) begin
      bx = 0;
      if (by + 1 >= mVT) begin
        by = 0;
        setTiming(pendH, pendV);
      end else by++;
    end else bx++;
    if (we) begin
      case (addr)
        2'd0: pendH = data;
        2'd1: pendV = data;
        2'd2: begin mVid = data[0]; mForce = data[1]; mCur = data[2]; end
        default: ;
      endcase
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitFrame();
    int s = frameSeen;
    while (frameSeen == s) step(1'b0, 2'd0, 32'h0);
  endtask

  initial begin
    int prevW;
    pendH = H_RST; pendV = V_RST;
    setTiming(H_RST, V_RST);
    bx = 0; by = 0; mVid = 0; mForce = 0; mCur = 0;
    frameCnt = 0; act0 = 0; line0Len = 0; frameSeen = 0; lineDone = 0;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 blankOut in reset", int'(blankOut), 1);
    chk("R10 hSyncN in reset", int'(hSyncN), 1);
    chk("R10 vSyncN in reset", int'(vSyncN), 1);
    chk("R10 cursorEn in reset", int'(cursorEn), 0);
    chk("R10 posX in reset", int'(posX), 0);
    chk("R10 posY in reset", int'(posY), 0);
    chk("R10 activeVideo at origin", int'(activeVideo), 1);
    rstN = 1'b1;

    step(1'b1, 2'd2, 32'h5); // video on, cursor on
    prevW = 16;
    for (int i = 0; i < NVEC; i++) begin
      waitFrame();
      step(1'b1, 2'd0, VECS[i].h);
      step(1'b1, 2'd1, VECS[i].v);
      waitFrame();
      chk("R6 frame in flight keeps old width", fAct0, prevW);
      waitFrame();
      chk("R2 R3 decoded active width", fAct0, VECS[i].w);
      chk("R1 line length", fLine, VECS[i].line);
      chk("R4 frame length", fLen, VECS[i].frame);
      prevW = VECS[i].w;
    end

    // R7: enabled video unblanks, cursor off
    step(1'b1, 2'd2, 32'h1);
    do step(1'b0, 2'd0, 32'h0); while (!lastActive);
    chk("R7 blank low with video on", int'(lastBlank), 0);
    chk("R7 cursorEn cleared", int'(cursorEn), 0);

    // R7: forced blank, counters still moving
    step(1'b1, 2'd2, 32'h3);
    do step(1'b0, 2'd0, 32'h0); while (!(lastActive && lastPosX != 0));
    chk("R7 forced blank", int'(lastBlank), 1);
    chk("R7 counters run while blanked", int'(lastPosX != 0), 1);

    // R8: active flag and frames continue with video disabled
    step(1'b1, 2'd2, 32'h0);
    waitFrame();
    waitFrame();
    chk("R8 frame length with video off", fLen, 108);

    // R9: coordinates zero outside active
    do step(1'b0, 2'd0, 32'h0); while (lastActive);
    chk("R9 posX zero when inactive", lastPosX, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule